// File: doc/BRIEF.md
# Indirect Instruction Memory Loader

This block sits between a host register bus and the instruction memories of embedded processors. It serves two planes by default, X and Y. Each plane has a private instruction memory, a private processor-reset input and one indirect access register. The host never addresses memory directly. It writes a single command word that carries the target address, and either the instruction data with a write bit or a read bit alone. The plane then completes the transfer by itself. For a read, the host polls a completion bit and then collects the word from the same register.

Each stored word carries one extra parity bit, chosen so that the stored word plus that bit has an even number of ones. The bit is checked on every host read and on every fetch the processor makes. A mismatch sets a per-plane interrupt level. That level stays set until the block reset. To exercise this path, a command may ask for the parity bit to be stored inverted.

Each plane runs a four-state machine:

- IDLE: no transfer is in flight.
- WRITE: memory is written in this cycle.
- RD_ADDR: the memory read is issued.
- RD_DATA: the read word travels through the second pipeline stage.

The transitions are as follows:

- IDLE or WRITE goes to WRITE on a command with the write bit set.
- IDLE or WRITE goes to RD_ADDR on a command with only the read bit set.
- IDLE or WRITE goes to IDLE on a cycle with no command.
- RD_ADDR always goes to RD_DATA.
- RD_DATA always goes to IDLE.

While the plane is in RD_ADDR, a host read owns the memory read port and a processor fetch is refused in that cycle.

Top module: `imem_loader`

## Requirements
- R1: After the block reset, every access register reads zero, and every status register reads zero. No fetch-valid output is high and no interrupt output is high.
- R2: A command written to a plane's access register with bit 24 set stores bits 15:0 at the memory address held in bits 23:16. Write commands may arrive on consecutive clock cycles, and every one of them is stored.
- R3: A command with bit 25 set and bit 24 clear sets the completion bit (bit 31) two clock edges after the edge that captured the command. At that point bits 15:0 hold the stored word and bits 23:16 hold the requested address.
- R4: While a read is in flight, the access register shows bit 30 (busy) high and bit 31 low. Any command written in that window is dropped and has no effect.
- R5: Every accepted command clears bit 31 at the edge that captures it.
- R6: A command with both bit 24 and bit 25 set performs only the write. No completion bit is set and the register never shows busy.
- R7: The access register for plane p sits at 0x40 + 0x20·p, and the status register for plane p sits at 0x10 + 0x20·p. Commands affect only the memory of the plane they address.
- R8: A fetch request made while the plane's processor-reset input is low returns the stored word with fetch-valid high two clock edges later. A fetch request made while that input is high returns nothing.
- R9: A command with bit 26 set stores the word with an inverted parity bit. A host read or a processor fetch of such a word sets status bit 0 and the plane's interrupt output. These stay set through further traffic and through processor reset, and clear only at the block reset. Words stored with correct parity never set them.
- R10: The enable bits are self-clearing, so bits 24 and 25 of the access register always read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous block reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | BUS_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cpu_rst | input | NPLANE | Per-plane processor reset, active high |
| fetch_en | input | NPLANE | Per-plane instruction fetch request |
| fetch_addr | input | NPLANE×ADDR_W | Per-plane fetch address |
| fetch_data | output | NPLANE×DATA_W | Per-plane fetched instruction |
| fetch_vld | output | NPLANE | Per-plane fetch data valid |
| irq | output | NPLANE | Per-plane sticky parity interrupt |

## Verification
The assertions make several assumptions about the inputs:

- The block reset is held across at least one clock edge before any check matters.
- The host holds each register write for exactly one edge.
- A processor reset that is high at an edge is meant to suppress any fetch result due at the next edge.

The stimulus drives every input on the falling clock edge and issues bus writes as single-cycle strobes. It only uses instruction data and addresses that fit bits 15:0 and 23:16. It requests fetches on one plane at a time, so the scoreboard queue sees results in the same order as the requests.

// File: rtl/imem_loader_pkg.sv
package imem_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_ADDR,
        ST_RD_DATA
    } plane_state_e;

    localparam int REG_W        = 32;
    localparam int FLD_ADDR_LSB = 16;
    localparam int BIT_WE       = 24;
    localparam int BIT_RE       = 25;
    localparam int BIT_BADPAR   = 26;
    localparam int BIT_BUSY     = 30;
    localparam int BIT_RDONE    = 31;
    localparam int BIT_IRQ      = 0;

endpackage

// File: rtl/imem_parity_ram.sv
module imem_parity_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wbad,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] q_data,
    output logic              q_par
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W:0] mem [DEPTH];
    logic            wpar;

    // Even parity: stored word plus parity bit has an even number of ones.
    assign wpar = (^wdata) ^ wbad;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wpar, wdata};
        end
    end

    // First read stage: registered array output.
    always_ff @(posedge clk) begin
        if (re) begin
            {q_par, q_data} <= mem[raddr];
        end
    end

endmodule

// File: rtl/imem_bus_decode.sv
module imem_bus_decode
    import imem_loader_pkg::*;
#(
    parameter int              NPLANE    = 2,
    parameter int              BUS_AW    = 8,
    parameter logic [BUS_AW-1:0] ACC_BASE  = 8'h40,
    parameter logic [BUS_AW-1:0] STAT_BASE = 8'h10,
    parameter logic [BUS_AW-1:0] STRIDE    = 8'h20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [BUS_AW-1:0]             reg_addr,
    input  logic [NPLANE-1:0][REG_W-1:0]  acc_rdata,
    input  logic [NPLANE-1:0][REG_W-1:0]  stat_rdata,
    output logic [NPLANE-1:0]             acc_wr,
    output logic [REG_W-1:0]              reg_rdata
);

    logic [NPLANE-1:0] acc_hit;
    logic [NPLANE-1:0] stat_hit;

    for (genvar p = 0; p < NPLANE; p++) begin : g_hit
        localparam logic [BUS_AW-1:0] ACC_OFS  = ACC_BASE  + BUS_AW'(p) * STRIDE;
        localparam logic [BUS_AW-1:0] STAT_OFS = STAT_BASE + BUS_AW'(p) * STRIDE;
        assign acc_hit[p]  = (reg_addr == ACC_OFS);
        assign stat_hit[p] = (reg_addr == STAT_OFS);
        assign acc_wr[p]   = reg_wr && acc_hit[p];
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPLANE; p++) begin
            if (acc_hit[p]) begin
                reg_rdata = acc_rdata[p];
            end
            if (stat_hit[p]) begin
                reg_rdata = stat_rdata[p];
            end
        end
    end

    // R7: one bus write never reaches two planes.
    p_one_plane_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_wr));

endmodule

// File: rtl/imem_plane_ctrl.sv
module imem_plane_ctrl
    import imem_loader_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rst,
    input  logic              acc_wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  acc_rdata,
    output logic [REG_W-1:0]  stat_rdata,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fetch_vld,
    output logic              irq
);

    plane_state_e st_q, st_d;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_bad;
    logic              rdone;
    logic              host_s1;
    logic              fetch_s1;

    logic              busy;
    logic              cmd_accept;
    logic              ram_we;
    logic              host_re;
    logic              fetch_grant;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_raddr;
    logic [DATA_W-1:0] q_data;
    logic              q_par;
    logic              par_err;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_WRITE: begin
                if (acc_wr && wdata[BIT_WE]) begin
                    st_d = ST_WRITE;
                end else if (acc_wr && wdata[BIT_RE]) begin
                    st_d = ST_RD_ADDR;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_RD_ADDR: st_d = ST_RD_DATA;
            ST_RD_DATA: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // State-decoded controls.
    always_comb begin
        busy        = (st_q == ST_RD_ADDR) || (st_q == ST_RD_DATA);
        cmd_accept  = acc_wr && !busy;
        ram_we      = (st_q == ST_WRITE);
        host_re     = (st_q == ST_RD_ADDR);
        fetch_grant = fetch_en && !cpu_rst && !host_re;
        ram_re      = host_re || fetch_grant;
        ram_raddr   = host_re ? cmd_addr : fetch_addr;
    end

    imem_parity_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .waddr  (cmd_addr),
        .wdata  (cmd_data),
        .wbad   (cmd_bad),
        .re     (ram_re),
        .raddr  (ram_raddr),
        .q_data (q_data),
        .q_par  (q_par)
    );

    assign par_err = ^{q_par, q_data};

    // Command register, second read stage and sticky interrupt.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_addr   <= '0;
            cmd_data   <= '0;
            cmd_bad    <= 1'b0;
            rdone      <= 1'b0;
            host_s1    <= 1'b0;
            fetch_s1   <= 1'b0;
            fetch_vld  <= 1'b0;
            fetch_data <= '0;
            irq        <= 1'b0;
        end else begin
            host_s1   <= host_re;
            fetch_s1  <= fetch_grant;
            fetch_vld <= fetch_s1 && !cpu_rst;
            if (fetch_s1) begin
                fetch_data <= q_data;
            end
            if (cmd_accept) begin
                cmd_addr <= wdata[FLD_ADDR_LSB +: ADDR_W];
                cmd_data <= wdata[DATA_W-1:0];
                cmd_bad  <= wdata[BIT_BADPAR];
                rdone    <= 1'b0;
            end else if (host_s1) begin
                cmd_data <= q_data;
                rdone    <= 1'b1;
            end
            if ((host_s1 || fetch_s1) && par_err) begin
                irq <= 1'b1;
            end
        end
    end

    // Register views.
    always_comb begin
        acc_rdata                             = '0;
        acc_rdata[DATA_W-1:0]                 = cmd_data;
        acc_rdata[FLD_ADDR_LSB +: ADDR_W]     = cmd_addr;
        acc_rdata[BIT_BUSY]                   = busy;
        acc_rdata[BIT_RDONE]                  = rdone;
        stat_rdata                            = '0;
        stat_rdata[BIT_IRQ]                   = irq;
    end

    // R4: completion and busy never show together.
    p_rdone_busy_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(rdone && busy));

    // R5: an accepted command leaves completion low.
    p_cmd_clears_rdone_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> !rdone);

    // R3: completion rises exactly two edges after the read was issued.
    p_rdone_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rdone) |-> ($past(st_q, 2) == ST_RD_ADDR));

    // R9: the parity interrupt never drops outside the block reset.
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        irq |=> irq);

    // R8: a processor held in reset sees no fetch result.
    p_fetch_held_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_rst) |-> !fetch_vld);

    // R6: a combined write and read command never makes the plane busy.
    p_combined_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept && wdata[BIT_WE] && wdata[BIT_RE]) |=> !busy);

endmodule

// File: rtl/imem_loader.sv
module imem_loader
    import imem_loader_pkg::*;
#(
    parameter int                NPLANE    = 2,
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter int                BUS_AW    = 8,
    parameter logic [BUS_AW-1:0] ACC_BASE  = 8'h40,
    parameter logic [BUS_AW-1:0] STAT_BASE = 8'h10,
    parameter logic [BUS_AW-1:0] STRIDE    = 8'h20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_wr,
    input  logic [BUS_AW-1:0]              reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic [NPLANE-1:0]              cpu_rst,
    input  logic [NPLANE-1:0]              fetch_en,
    input  logic [NPLANE-1:0][ADDR_W-1:0]  fetch_addr,
    output logic [NPLANE-1:0][DATA_W-1:0]  fetch_data,
    output logic [NPLANE-1:0]              fetch_vld,
    output logic [NPLANE-1:0]              irq
);

    logic [NPLANE-1:0]            acc_wr;
    logic [NPLANE-1:0][REG_W-1:0] acc_rdata;
    logic [NPLANE-1:0][REG_W-1:0] stat_rdata;

    imem_bus_decode #(
        .NPLANE    (NPLANE),
        .BUS_AW    (BUS_AW),
        .ACC_BASE  (ACC_BASE),
        .STAT_BASE (STAT_BASE),
        .STRIDE    (STRIDE)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .acc_rdata  (acc_rdata),
        .stat_rdata (stat_rdata),
        .acc_wr     (acc_wr),
        .reg_rdata  (reg_rdata)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        imem_plane_ctrl #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_plane (
            .clk        (clk),
            .rst        (rst),
            .cpu_rst    (cpu_rst[p]),
            .acc_wr     (acc_wr[p]),
            .wdata      (reg_wdata),
            .acc_rdata  (acc_rdata[p]),
            .stat_rdata (stat_rdata[p]),
            .fetch_en   (fetch_en[p]),
            .fetch_addr (fetch_addr[p]),
            .fetch_data (fetch_data[p]),
            .fetch_vld  (fetch_vld[p]),
            .irq        (irq[p])
        );
    end

endmodule

// File: tb/tb_imem_loader.sv
module tb_imem_loader;

    localparam int NP = 2;
    localparam int DW = 16;
    localparam int AW = 8;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   reg_wr;
    logic [7:0]             reg_addr;
    logic [31:0]            reg_wdata;
    logic [31:0]            reg_rdata;
    logic [NP-1:0]          cpu_rst;
    logic [NP-1:0]          fetch_en;
    logic [NP-1:0][AW-1:0]  fetch_addr;
    logic [NP-1:0][DW-1:0]  fetch_data;
    logic [NP-1:0]          fetch_vld;
    logic [NP-1:0]          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int          plane;
        logic [15:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    imem_loader dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_rst(cpu_rst),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_vld(fetch_vld), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] acc_ofs(input int p);
        return 8'(8'h40 + 8'h20 * p);
    endfunction

    function automatic logic [7:0] stat_ofs(input int p);
        return 8'(8'h10 + 8'h20 * p);
    endfunction

    function automatic logic [31:0] mk_cmd(input bit we, input bit re, input bit bad,
                                           input logic [7:0] a, input logic [15:0] d);
        return {5'b0, bad, re, we, a, d};
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic host_read(input int p, input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [31:0] v;
        bus_wr(acc_ofs(p), mk_cmd(0, 1, 0, a, 16'h0));
        bus_rd(acc_ofs(p), v);
        chk(v[30] && !v[31], "R4 busy while pending", v, 32'h4000_0000);
        @(negedge clk);
        bus_rd(acc_ofs(p), v);
        chk(v[30] && !v[31], "R4 busy second cycle", v, 32'h4000_0000);
        @(negedge clk);
        bus_rd(acc_ofs(p), v);
        chk(v == {8'h80, a, exp}, {"R3 ", tag}, v, {8'h80, a, exp});
        chk(v[25:24] == 2'b00, "R10 enables clear", {30'b0, v[25:24]}, 32'h0);
    endtask

    task automatic fetch_req(input int p, input logic [7:0] a, input logic [15:0] exp, input bit expect_data);
        exp_t e;
        @(negedge clk);
        fetch_en[p] = 1'b1;
        fetch_addr[p] = a;
        if (expect_data) begin
            e.plane = p;
            e.data  = exp;
            exp_q.push_back(e);
        end
        @(negedge clk);
        fetch_en[p] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor for the fetch ports (R8).
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (fetch_vld[p]) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 unexpected fetch result", 32'(fetch_data[p]), 32'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(e.plane == p && fetch_data[p] == e.data, "R8 fetched word",
                            32'(fetch_data[p]), 32'(e.data));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] img [8];

        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        cpu_rst = '1; fetch_en = '0; fetch_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state.
        for (int p = 0; p < NP; p++) begin
            bus_rd(acc_ofs(p), v);
            chk(v == 32'h0, "R1 access reg after reset", v, 32'h0);
            bus_rd(stat_ofs(p), v);
            chk(v == 32'h0, "R1 status reg after reset", v, 32'h0);
        end
        chk(fetch_vld == '0 && irq == '0, "R1 outputs after reset", {28'b0, fetch_vld, irq}, 32'h0);

        // R2: back-to-back write burst into plane X.
        for (int i = 0; i < 8; i++) img[i] = 16'(16'h1000 + 16'h0111 * i);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            reg_wr = 1'b1;
            reg_addr = acc_ofs(0);
            reg_wdata = mk_cmd(1, 0, 0, 8'(i), img[i]);
            @(negedge clk);
        end
        reg_wr = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i += 3) host_read(0, 8'(i), img[i], "R2 burst word read back");

        // R7: planes are independent.
        bus_wr(acc_ofs(1), mk_cmd(1, 0, 0, 8'd3, 16'hBEEF));
        host_read(1, 8'd3, 16'hBEEF, "R7 plane Y word");
        host_read(0, 8'd3, img[3], "R7 plane X untouched");

        // R4: command during a pending read is dropped.
        bus_wr(acc_ofs(0), mk_cmd(0, 1, 0, 8'd1, 16'h0));
        bus_wr(acc_ofs(0), mk_cmd(1, 0, 0, 8'd1, 16'hDEAD));
        @(negedge clk);
        bus_rd(acc_ofs(0), v);
        chk(v == {8'h80, 8'd1, img[1]}, "R4 pending read unaffected", v, {8'h80, 8'd1, img[1]});
        host_read(0, 8'd1, img[1], "R4 dropped write left memory");

        // R5: a new command clears completion.
        bus_wr(acc_ofs(0), mk_cmd(1, 0, 0, 8'd20, 16'h0055));
        bus_rd(acc_ofs(0), v);
        chk(!v[31], "R5 completion cleared", v, 32'h0);

        // R6: both enables set performs only the write.
        bus_wr(acc_ofs(0), mk_cmd(1, 1, 0, 8'd21, 16'h0077));
        bus_rd(acc_ofs(0), v);
        chk(v[31:30] == 2'b00, "R6 not busy after combined", v, {8'h00, 8'd21, 16'h0077});
        repeat (3) @(negedge clk);
        bus_rd(acc_ofs(0), v);
        chk(v == {8'h00, 8'd21, 16'h0077}, "R6 no completion", v, {8'h00, 8'd21, 16'h0077});
        host_read(0, 8'd21, 16'h0077, "R6 word written");

        // R8: fetch held in reset returns nothing, then runs after release.
        fetch_req(0, 8'd2, 16'h0, 0);
        chk(exp_q.size() == 0 && fetch_vld == '0, "R8 no fetch in reset", 32'(fetch_vld), 32'h0);
        cpu_rst[0] = 1'b0;
        fetch_req(0, 8'd2, img[2], 1);
        fetch_req(0, 8'd20, 16'h0055, 1);
        chk(exp_q.size() == 0, "R8 all fetches answered", exp_q.size(), 32'h0);

        // R9: bad parity seen by a host read on plane Y.
        bus_wr(acc_ofs(1), mk_cmd(1, 0, 1, 8'd9, 16'h1234));
        @(negedge clk);
        bus_rd(stat_ofs(1), v);
        chk(v == 32'h0, "R9 no irq before read", v, 32'h0);
        host_read(1, 8'd9, 16'h1234, "R9 bad-parity word data");
        bus_rd(stat_ofs(1), v);
        chk(v == 32'h1 && irq == 2'b10, "R9 irq Y set", {v[30:0], irq[1]}, 32'h3);
        bus_rd(stat_ofs(0), v);
        chk(v == 32'h0, "R9 good words leave X clear", v, 32'h0);
        cpu_rst[1] = 1'b0;
        repeat (2) @(negedge clk);
        cpu_rst[1] = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(stat_ofs(1), v);
        chk(v == 32'h1, "R9 irq sticky across processor reset", v, 32'h1);

        // R9: bad parity seen by a fetch on plane X.
        bus_wr(acc_ofs(0), mk_cmd(1, 0, 1, 8'd30, 16'h00F0));
        fetch_req(0, 8'd30, 16'h00F0, 1);
        bus_rd(stat_ofs(0), v);
        chk(v == 32'h1 && irq[0], "R9 irq X from fetch", v, 32'h1);

        // R9 / R1: only the block reset clears the interrupt.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_rd(stat_ofs(0), v);
        chk(v == 32'h0, "R9 X cleared by block reset", v, 32'h0);
        bus_rd(stat_ofs(1), v);
        chk(v == 32'h0 && irq == '0, "R9 Y cleared by block reset", v, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule